// File: doc/BRIEF.md
# Next Instruction Pointer Unit

This unit keeps the code segment and instruction pointer of a 16-bit segmented processor and works out their next values. When the advance strobe is high, it uses the flow kind of the current instruction to choose the next pair. Plain sequential flow steps the pointer past the current instruction. A relative transfer adds a signed displacement to the address of the following instruction. A far direct transfer takes both words from the instruction. A near or far indirect transfer takes its words from memory.

Decode and memory access sit upstream. The caller presents the instruction length, the flow kind, the displacement and its width flag, two immediate words and two memory words. Both outputs are registered. They hold between strobes and return to a fixed start vector on reset.

Top module: `nip_unit`

## Requirements
- R1: On reset, seg_q takes RESET_SEG and ptr_q takes RESET_PTR (defaults 16'hFFFF and 16'h0000).
- R2: While step is low, seg_q and ptr_q keep their values whatever the other inputs are.
- R3: With step high and kind = 3'd0 (sequential), ptr_q becomes (ptr_q + ilen) mod 65536 and seg_q is unchanged.
- R4: With kind = 3'd1 (relative) and wide = 1, ptr_q becomes (ptr_q + ilen + disp) mod 65536 and seg_q is unchanged.
- R5: With kind = 3'd1 and wide = 0, only disp[7:0] is used, sign-extended from bit 7 before it is added. disp[15:8] has no effect.
- R6: With kind = 3'd2 (far direct), ptr_q becomes imm_lo and seg_q becomes imm_hi.
- R7: With kind = 3'd3 (near indirect), ptr_q becomes mem_lo and seg_q is unchanged.
- R8: With kind = 3'd4 (far indirect), ptr_q becomes mem_lo (the first word) and seg_q becomes mem_hi (the second word).
- R9: Kind codes 5 to 7 behave as sequential. All pointer arithmetic wraps modulo 65536 with no carry into seg_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Advance strobe |
| kind | input | 3 | Flow kind code |
| ilen | input | 4 | Current instruction length in bytes |
| wide | input | 1 | 1 = 16-bit displacement, 0 = 8-bit |
| disp | input | 16 | Relative displacement |
| imm_lo | input | 16 | Immediate word loaded into the pointer |
| imm_hi | input | 16 | Immediate word loaded into the segment |
| mem_lo | input | 16 | First memory word (pointer) |
| mem_hi | input | 16 | Second memory word (segment) |
| seg_q | output | 16 | Code segment |
| ptr_q | output | 16 | Instruction pointer |

## Verification
The assertions assume that inputs are stable at each rising edge. They also assume that nothing checks the outputs in the cycle reset is released, so every check looks back only one cycle after reset has been low. The stimulus drives inputs on the falling edge and gives each step cycle exactly one kind code. It also picks pointer and displacement values that cross the 16-bit wrap boundary in both directions, so the modulo behaviour is exercised and not just assumed.

// File: rtl/nip_pkg.sv
package nip_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LEN_W  = 4;

  typedef enum logic [2:0] {
    FLOW_SEQ      = 3'd0,
    FLOW_REL      = 3'd1,
    FLOW_FAR_DIR  = 3'd2,
    FLOW_NEAR_IND = 3'd3,
    FLOW_FAR_IND  = 3'd4
  } flow_e;

  function automatic logic [WORD_W-1:0] fall_through(
    input logic [WORD_W-1:0] ptr, input logic [LEN_W-1:0] len);
    return ptr + WORD_W'(len);
  endfunction

  function automatic logic [WORD_W-1:0] widen_disp(
    input logic [WORD_W-1:0] d, input logic is_wide);
    return is_wide ? d : {{(WORD_W-8){d[7]}}, d[7:0]};
  endfunction
endpackage

// File: rtl/nip_target.sv
module nip_target
  import nip_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter int unsigned L = LEN_W
) (
  input  logic [2:0]   kind,
  input  logic [W-1:0] cur_ptr,
  input  logic [W-1:0] cur_seg,
  input  logic [L-1:0] ilen,
  input  logic         wide,
  input  logic [W-1:0] disp,
  input  logic [W-1:0] imm_lo,
  input  logic [W-1:0] imm_hi,
  input  logic [W-1:0] mem_lo,
  input  logic [W-1:0] mem_hi,
  output logic [W-1:0] nxt_ptr,
  output logic [W-1:0] nxt_seg,
  output logic         seg_load
);
  logic [W-1:0] after_ptr;
  logic [W-1:0] ext_disp;

  always_comb begin
    after_ptr = fall_through(cur_ptr, ilen);
    ext_disp  = widen_disp(disp, wide);
    nxt_ptr   = after_ptr;
    nxt_seg   = cur_seg;
    seg_load  = 1'b0;
    case (kind)
      FLOW_REL:      nxt_ptr = after_ptr + ext_disp;
      FLOW_FAR_DIR:  begin nxt_ptr = imm_lo; nxt_seg = imm_hi; seg_load = 1'b1; end
      FLOW_NEAR_IND: nxt_ptr = mem_lo;
      FLOW_FAR_IND:  begin nxt_ptr = mem_lo; nxt_seg = mem_hi; seg_load = 1'b1; end
      default:       nxt_ptr = after_ptr;
    endcase
  end
endmodule

// File: rtl/nip_state.sv
module nip_state #(
  parameter int unsigned  W       = 16,
  parameter logic [W-1:0] INIT_SEG = '1,
  parameter logic [W-1:0] INIT_PTR = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_seg,
  input  logic [W-1:0] d_ptr,
  output logic [W-1:0] q_seg,
  output logic [W-1:0] q_ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_seg <= INIT_SEG;
      q_ptr <= INIT_PTR;
    end else if (en) begin
      q_seg <= d_seg;
      q_ptr <= d_ptr;
    end
  end
endmodule

// File: rtl/nip_unit.sv
module nip_unit
  import nip_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [WORD_W-1:0] RESET_PTR = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [2:0]        kind,
  input  logic [LEN_W-1:0]  ilen,
  input  logic              wide,
  input  logic [WORD_W-1:0] disp,
  input  logic [WORD_W-1:0] imm_lo,
  input  logic [WORD_W-1:0] imm_hi,
  input  logic [WORD_W-1:0] mem_lo,
  input  logic [WORD_W-1:0] mem_hi,
  output logic [WORD_W-1:0] seg_q,
  output logic [WORD_W-1:0] ptr_q
);
  logic [WORD_W-1:0] nxt_ptr, nxt_seg;
  logic              seg_load;

  nip_target #(.W(WORD_W), .L(LEN_W)) u_target (
    .kind(kind), .cur_ptr(ptr_q), .cur_seg(seg_q), .ilen(ilen), .wide(wide),
    .disp(disp), .imm_lo(imm_lo), .imm_hi(imm_hi), .mem_lo(mem_lo),
    .mem_hi(mem_hi), .nxt_ptr(nxt_ptr), .nxt_seg(nxt_seg), .seg_load(seg_load)
  );

  nip_state #(.W(WORD_W), .INIT_SEG(RESET_SEG), .INIT_PTR(RESET_PTR)) u_state (
    .clk(clk), .rst_n(rst_n), .en(step), .d_seg(nxt_seg), .d_ptr(nxt_ptr),
    .q_seg(seg_q), .q_ptr(ptr_q)
  );
endmodule

// File: rtl/nip_unit_chk.sv
module nip_unit_chk
  import nip_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [WORD_W-1:0] RESET_PTR = 16'h0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic [2:0]        kind,
  input logic [LEN_W-1:0]  ilen,
  input logic              wide,
  input logic [WORD_W-1:0] disp,
  input logic [WORD_W-1:0] imm_hi,
  input logic [WORD_W-1:0] mem_lo,
  input logic [WORD_W-1:0] mem_hi,
  input logic [WORD_W-1:0] seg_q,
  input logic [WORD_W-1:0] ptr_q,
  input logic              seg_load
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= !rst_n;

  assert_reset_vec_R1: assert property (@(posedge clk)
    was_rst && rst_n |-> (seg_q == RESET_SEG && ptr_q == RESET_PTR));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || was_rst)
    $past(!step) |-> ($stable(seg_q) && $stable(ptr_q)));

  assert_seq_R3: assert property (@(posedge clk) disable iff (!rst_n || was_rst)
    $past(step && kind == 3'd0) |-> ptr_q == 16'($past(ptr_q) + 16'($past(ilen))));

  assert_rel_seg_R4: assert property (@(posedge clk) disable iff (!rst_n || was_rst)
    $past(step && kind == 3'd1) |-> seg_q == $past(seg_q));

  assert_rel_short_R5: assert property (@(posedge clk) disable iff (!rst_n || was_rst)
    $past(step && kind == 3'd1 && !wide) |->
      ptr_q == 16'($past(ptr_q) + 16'($past(ilen)) + {{8{$past(disp[7])}}, $past(disp[7:0])}));

  assert_far_dir_R6: assert property (@(posedge clk) disable iff (!rst_n || was_rst)
    $past(step && kind == 3'd2) |-> seg_q == $past(imm_hi));

  assert_near_ind_R7: assert property (@(posedge clk) disable iff (!rst_n || was_rst)
    $past(step && kind == 3'd3) |-> (ptr_q == $past(mem_lo) && seg_q == $past(seg_q)));

  assert_far_ind_R8: assert property (@(posedge clk) disable iff (!rst_n || was_rst)
    $past(step && kind == 3'd4) |-> (ptr_q == $past(mem_lo) && seg_q == $past(mem_hi)));

  assert_seg_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seg_load |-> (kind == 3'd2 || kind == 3'd4));
endmodule

bind nip_unit nip_unit_chk #(.RESET_SEG(RESET_SEG), .RESET_PTR(RESET_PTR)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .kind(kind), .ilen(ilen), .wide(wide),
  .disp(disp), .imm_hi(imm_hi), .mem_lo(mem_lo), .mem_hi(mem_hi),
  .seg_q(seg_q), .ptr_q(ptr_q), .seg_load(seg_load)
);

// File: tb/nip_unit_test.sv
module nip_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [2:0]  kind = '0;
  logic [3:0]  ilen = '0;
  logic        wide = 1'b0;
  logic [15:0] disp = '0, imm_lo = '0, imm_hi = '0, mem_lo = '0, mem_hi = '0;
  logic [15:0] seg_q, ptr_q;
  int vectors = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nip_unit uut (.*);

  task automatic check(input string req, input logic [15:0] seg_e, input logic [15:0] ptr_e);
    vectors++;
    if (seg_q !== seg_e || ptr_q !== ptr_e) begin
      bad++;
      $display("FAIL %s: seg=%h ptr=%h expected seg=%h ptr=%h", req, seg_q, ptr_q, seg_e, ptr_e);
    end
  endtask

  task automatic do_step(input logic [2:0] k, input logic [3:0] len, input logic w,
                         input logic [15:0] d, input logic [15:0] il, input logic [15:0] ih,
                         input logic [15:0] ml, input logic [15:0] mh);
    @(negedge clk);
    step = 1; kind = k; ilen = len; wide = w; disp = d;
    imm_lo = il; imm_hi = ih; mem_lo = ml; mem_hi = mh;
    @(negedge clk);
    step = 0;
  endtask

  task automatic set_cs_ip(input logic [15:0] s, input logic [15:0] p);
    do_step(3'd2, 4'd5, 0, 0, p, s, 0, 0);
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    check("R1", 16'hFFFF, 16'h0000);
  endtask

  task automatic t_hold;
    set_cs_ip(16'h1234, 16'h0100);
    @(negedge clk);
    kind = 3'd2; imm_lo = 16'hDEAD; imm_hi = 16'hBEEF; mem_lo = 16'h5555; ilen = 4'd7;
    repeat (3) @(negedge clk);
    check("R2", 16'h1234, 16'h0100);
  endtask

  task automatic t_seq;
    set_cs_ip(16'h2000, 16'h0010);
    do_step(3'd0, 4'd3, 0, 0, 0, 0, 0, 0);
    check("R3", 16'h2000, 16'h0013);
    set_cs_ip(16'h2000, 16'hFFFE);
    do_step(3'd0, 4'd4, 0, 0, 0, 0, 0, 0);
    check("R3 wrap R9", 16'h2000, 16'h0002);
  endtask

  task automatic t_rel;
    set_cs_ip(16'h3000, 16'h1000);
    do_step(3'd1, 4'd3, 1, 16'h0200, 0, 0, 0, 0);
    check("R4", 16'h3000, 16'h1203);
    set_cs_ip(16'h3000, 16'h1000);
    do_step(3'd1, 4'd3, 1, 16'hFF00, 0, 0, 0, 0);
    check("R4 negative", 16'h3000, 16'h0F03);
    set_cs_ip(16'h3000, 16'h0005);
    do_step(3'd1, 4'd2, 1, 16'hFFF0, 0, 0, 0, 0);
    check("R4 wrap R9", 16'h3000, 16'hFFF7);
  endtask

  task automatic t_short;
    set_cs_ip(16'h4000, 16'h0100);
    do_step(3'd1, 4'd2, 0, 16'hAB80, 0, 0, 0, 0);
    check("R5 negative", 16'h4000, 16'h0082);
    set_cs_ip(16'h4000, 16'h0100);
    do_step(3'd1, 4'd2, 0, 16'hFF7F, 0, 0, 0, 0);
    check("R5 high byte ignored", 16'h4000, 16'h0181);
  endtask

  task automatic t_far;
    set_cs_ip(16'h5000, 16'h0100);
    do_step(3'd2, 4'd5, 0, 16'h7777, 16'hABCD, 16'hF000, 16'h1111, 16'h2222);
    check("R6", 16'hF000, 16'hABCD);
    do_step(3'd3, 4'd2, 0, 0, 16'h9999, 16'h8888, 16'h4321, 16'h2222);
    check("R7", 16'hF000, 16'h4321);
    do_step(3'd4, 4'd2, 0, 0, 16'h9999, 16'h8888, 16'h6789, 16'h0C00);
    check("R8", 16'h0C00, 16'h6789);
  endtask

  task automatic t_other;
    set_cs_ip(16'h6000, 16'h0040);
    do_step(3'd5, 4'd1, 1, 16'h1000, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    check("R9 kind5", 16'h6000, 16'h0041);
    do_step(3'd7, 4'd15, 1, 16'h1000, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    check("R9 kind7", 16'h6000, 16'h0050);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_seq();
    t_rel();
    t_short();
    t_far();
    t_other();
    t_reset();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule